// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multiple-register memory request into a series of single-word transfers. A request gives a 32-bit base value, a 16-bit mask of the registers to move, one of four address orderings and a write-back select. After the start strobe the block walks the mask from the lowest register to the highest. For each register it presents a register index and a word address on a valid/ready transfer port. The addresses step by 4 bytes from the lowest address of the block. The register file and the memory data path sit outside and consume these transfers.

The transfer port follows valid/ready rules. A transfer completes on a clock edge where valid and ready are both high. While valid is high and ready is low, the index and address stay fixed and valid stays high. Ready has no effect while valid is low. When the last transfer has completed, the block pulses done for one cycle. In the same cycle it presents the adjusted base value, and it asserts a write enable for that value if write-back was selected. The start strobe and the busy flag are plain control pins.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, valid, done, busy and the write enable are low.
- R2: The mode code is 2 bits wide: 0 is increment-after, 1 is increment-before, 2 is decrement-after and 3 is decrement-before. In increment-after mode the first address is the base, and each later transfer adds 4 to the previous address.
- R3: In increment-before mode the first address is base+4, and the addresses rise by 4 from there.
- R4: In decrement-after mode the lowest address is base−4×N+4, where N is the number of set bits in the mask.
- R5: In decrement-before mode the lowest address is base−4×N.
- R6: Registers are issued in ascending index order. The lowest set bit goes to the lowest address. Bit i of the mask selects register i, and gaps in the mask are skipped.
- R7: While valid is high and ready is low, valid, the index and the address hold their values.
- R8: Done is high for exactly one cycle, in the cycle after the last transfer completes. In that cycle the base output is base+4×N for increment modes and base−4×N for decrement modes.
- R9: The write enable is high only in the done cycle, and only when write-back was selected.
- R10: An empty mask performs no transfer. Done rises in the cycle after start, the write enable stays low and the base output equals the base input.
- R11: A start strobe while busy is high is ignored, and the sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| base_i | input | 32 | Base address of the request |
| rmask_i | input | 16 | Register mask, bit i selects register i |
| mode_i | input | 2 | Address ordering code |
| wb_sel_i | input | 1 | Request update of the base register |
| busy_o | output | 1 | A request is in progress |
| xfer_valid_o | output | 1 | Transfer offered |
| xfer_ready_i | input | 1 | Memory accepts the transfer |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| done_o | output | 1 | One-cycle end-of-request pulse |
| wb_we_o | output | 1 | Write enable for the updated base |
| wb_base_o | output | 32 | Updated base value, valid with done |

## Verification
A wrong pending mask or mask-advance step shows at the ports as a wrong register index on the next offered transfer. It also changes the transfer count, so done arrives one or more cycles early or late. A wrong start-address calculation or address counter shows as a wrong address on the very first transfer, or on the transfer after the faulty step. A wrong final-base computation appears only in the done cycle, as a wrong value on the base output. A stall fault shows as a changed address or index in the cycle after ready was held low.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    ORD_INC_AFTER  = 2'd0,
    ORD_INC_BEFORE = 2'd1,
    ORD_DEC_AFTER  = 2'd2,
    ORD_DEC_BEFORE = 2'd3
  } ord_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
  parameter int NREG = 16,
  localparam int CNTW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [CNTW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt_o = cnt_o + CNTW'(mask_i[i]);
    end
  end
endmodule

// File: rtl/blkx_lowpick.sv
module blkx_lowpick #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [IDXW-1:0] idx_o
);
  // Scan from the top so the lowest set bit is the last to win.
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDXW'(i);
    end
  end
endmodule

// File: rtl/blkx_addr_plan.sv
module blkx_addr_plan
  import blkx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNTW      = $clog2(NREG + 1),
  localparam int STEP_SH   = $clog2(WORD_BYTES)
) (
  input  logic [AW-1:0]   base_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic [1:0]      mode_i,
  output logic [AW-1:0]   low_addr_o,
  output logic [AW-1:0]   final_base_o
);
  logic [AW-1:0] span;
  logic [AW-1:0] step;
  logic          is_dec;
  logic          pre_step;

  assign span     = AW'(cnt_i) << STEP_SH;
  assign step     = AW'(WORD_BYTES);
  assign is_dec   = mode_i[1];
  assign pre_step = mode_i[0];

  always_comb begin
    if (is_dec) begin
      final_base_o = base_i - span;
      low_addr_o   = pre_step ? (base_i - span) : (base_i - span + step);
    end else begin
      final_base_o = base_i + span;
      low_addr_o   = pre_step ? (base_i + step) : base_i;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blkx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDXW      = $clog2(NREG),
  localparam int CNTW      = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] rmask_i,
  input  logic [1:0]      mode_i,
  input  logic            wb_sel_i,
  output logic            busy_o,
  output logic            xfer_valid_o,
  input  logic            xfer_ready_i,
  output logic [IDXW-1:0] xfer_reg_o,
  output logic [AW-1:0]   xfer_addr_o,
  output logic            done_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_base_o
);
  seq_st_e         st_q;
  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] pend_nx;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   fin_q;
  logic            wbreq_q;

  logic [CNTW-1:0] req_cnt;
  logic [AW-1:0]   plan_low;
  logic [AW-1:0]   plan_fin;
  logic            hs;

  blkx_popcnt #(.NREG(NREG)) u_cnt (
    .mask_i (rmask_i),
    .cnt_o  (req_cnt)
  );

  blkx_addr_plan #(.AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base_i       (base_i),
    .cnt_i        (req_cnt),
    .mode_i       (mode_i),
    .low_addr_o   (plan_low),
    .final_base_o (plan_fin)
  );

  blkx_lowpick #(.NREG(NREG)) u_pick (
    .mask_i (pend_q),
    .idx_o  (xfer_reg_o)
  );

  assign hs      = xfer_valid_o && xfer_ready_i;
  assign pend_nx = pend_q & (pend_q - NREG'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      fin_q   <= '0;
      wbreq_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            pend_q  <= rmask_i;
            addr_q  <= plan_low;
            fin_q   <= plan_fin;
            wbreq_q <= wb_sel_i && (|rmask_i);
            st_q    <= (|rmask_i) ? ST_MOVE : ST_FIN;
          end
        end
        ST_MOVE: begin
          if (xfer_ready_i) begin
            pend_q <= pend_nx;
            addr_q <= addr_q + AW'(WORD_BYTES);
            if (pend_nx == '0) st_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          st_q    <= ST_IDLE;
          wbreq_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign xfer_valid_o = (st_q == ST_MOVE);
  assign xfer_addr_o  = addr_q;
  assign done_o       = (st_q == ST_FIN);
  assign wb_we_o      = done_o && wbreq_q;
  assign wb_base_o    = fin_q;

  // R7: an offer that is not taken stays put
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));

  // R2: consecutive transfers of one request are one word apart
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs ##1 xfer_valid_o |-> xfer_addr_o == $past(xfer_addr_o) + AW'(WORD_BYTES));

  // R6: register indices rise within a request
  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs ##1 xfer_valid_o |-> xfer_reg_o > $past(xfer_reg_o));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: write enable only together with done
  p_wbwe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |-> done_o);

  // R11: nothing is offered while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!xfer_valid_o && !done_o));
endmodule

// File: tb/sim_blk_xfer_seq.sv
`timescale 1ns/1ps
module sim_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] rmask_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_sel_i = 1'b0;
  logic        busy_o, xfer_valid_o, done_o, wb_we_o;
  logic        xfer_ready_i = 1'b0;
  logic [3:0]  xfer_reg_o;
  logic [31:0] xfer_addr_o, wb_base_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  blk_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .rmask_i(rmask_i), .mode_i(mode_i), .wb_sel_i(wb_sel_i),
    .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o), .done_o(done_o),
    .wb_we_o(wb_we_o), .wb_base_o(wb_base_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {base, mask, mode, wb, ready pattern}
  localparam logic [58:0] VEC [6] = '{
    {32'd1000,      16'h00C3, 2'd0, 1'b1, 8'hFF},
    {32'h0000_0200, 16'h0007, 2'd1, 1'b1, 8'hB5},
    {32'h0000_2000, 16'h8001, 2'd2, 1'b1, 8'h5A},
    {32'h0000_2000, 16'h0F0F, 2'd3, 1'b0, 8'hC3},
    {32'hFFFF_FFF8, 16'hFFFF, 2'd0, 1'b1, 8'hFF},
    {32'h0000_0010, 16'h0010, 2'd3, 1'b1, 8'h3C}
  };

  task automatic run_req(input logic [31:0] b, input logic [15:0] m,
                         input logic [1:0] md, input logic w, input logic [7:0] pat);
    int          n = $countones(m);
    logic [31:0] lo, fin, ea;
    logic [15:0] rm = m;
    int          k = 0;
    bit          fin_due;
    bit          seen_done = 0;
    bit          held = 0;
    logic [31:0] h_addr;
    logic [3:0]  h_reg;
    int          er;
    string       mtag;
    case (md)
      2'd0: begin lo = b;                      mtag = "R2"; end
      2'd1: begin lo = b + 4;                  mtag = "R3"; end
      2'd2: begin lo = b - 32'(4*n) + 4;       mtag = "R4"; end
      default: begin lo = b - 32'(4*n);        mtag = "R5"; end
    endcase
    fin = md[1] ? b - 32'(4*n) : b + 32'(4*n);
    @(negedge clk);
    start_i = 1; base_i = b; rmask_i = m; mode_i = md; wb_sel_i = w;
    @(negedge clk);
    start_i = 0;
    fin_due = (n == 0);
    for (int cyc = 0; cyc < 200 && !seen_done; cyc++) begin
      if (cyc > 0) @(negedge clk);
      xfer_ready_i = pat[cyc % 8];
      #1;
      if (held) begin
        chk(xfer_valid_o && xfer_addr_o == h_addr && xfer_reg_o == h_reg,
            "R7 hold under stall", xfer_addr_o, h_addr);
        held = 0;
      end
      if (done_o) begin
        chk(fin_due, "R8 done timing", 32'(k), 32'(n));
        chk(wb_base_o == fin, "R8 final base", wb_base_o, fin);
        chk(wb_we_o == (w && n != 0), "R9 write enable", 32'(wb_we_o), 32'(w && n != 0));
        seen_done = 1;
      end else if (xfer_valid_o) begin
        er = 0;
        for (int i = 15; i >= 0; i--) if (rm[i]) er = i;
        ea = lo + 32'(4*k);
        chk(32'(xfer_reg_o) == 32'(er), "R6 register order", 32'(xfer_reg_o), 32'(er));
        chk(xfer_addr_o == ea, {mtag, " address"}, xfer_addr_o, ea);
        if (xfer_ready_i) begin
          rm[er] = 1'b0;
          k++;
          fin_due = (rm == 0);
        end else begin
          held = 1; h_addr = xfer_addr_o; h_reg = xfer_reg_o;
        end
      end else begin
        chk(0, "R8 no output while busy", 32'(busy_o), 1);
      end
    end
    chk(seen_done, "R8 done reached", 32'(seen_done), 1);
    @(negedge clk);
    chk(!done_o && !wb_we_o, "R8 done one cycle", 32'(done_o), 0);
    xfer_ready_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!xfer_valid_o && !done_o && !busy_o && !wb_we_o, "R1 reset state",
        {28'd0, xfer_valid_o, done_o, busy_o, wb_we_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !xfer_valid_o, "R1 idle after reset", 32'(busy_o), 0);

    for (int v = 0; v < 6; v++) begin
      run_req(VEC[v][58:27], VEC[v][26:11], VEC[v][10:9], VEC[v][8], VEC[v][7:0]);
    end

    // R10: empty mask
    @(negedge clk);
    start_i = 1; base_i = 32'h0000_4444; rmask_i = '0; mode_i = 2'd3; wb_sel_i = 1;
    xfer_ready_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(done_o && !xfer_valid_o, "R10 empty done next cycle", 32'(done_o), 1);
    chk(!wb_we_o, "R10 no write enable", 32'(wb_we_o), 0);
    chk(wb_base_o == 32'h0000_4444, "R10 base unchanged", wb_base_o, 32'h4444);
    @(negedge clk);
    chk(!done_o && !xfer_valid_o, "R10 no transfer", 32'(xfer_valid_o), 0);
    xfer_ready_i = 0;

    // R11: second start while busy
    @(negedge clk);
    start_i = 1; base_i = 32'h100; rmask_i = 16'h0003; mode_i = 2'd0; wb_sel_i = 1;
    @(negedge clk);
    start_i = 1; base_i = 32'h900; rmask_i = 16'h8000; mode_i = 2'd3;
    chk(xfer_valid_o && xfer_addr_o == 32'h100, "R11 first offer", xfer_addr_o, 32'h100);
    @(negedge clk);
    start_i = 0;
    chk(xfer_addr_o == 32'h100 && xfer_reg_o == 4'd0, "R11 start ignored", xfer_addr_o, 32'h100);
    xfer_ready_i = 1;
    @(negedge clk);
    chk(xfer_addr_o == 32'h104 && xfer_reg_o == 4'd1, "R11 sequence continues",
        xfer_addr_o, 32'h104);
    @(negedge clk);
    xfer_ready_i = 0;
    chk(done_o && wb_we_o && wb_base_o == 32'h108, "R11 original final base",
        wb_base_o, 32'h108);
    @(negedge clk);
    chk(!busy_o, "R11 idle again", 32'(busy_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule